// File: doc/BRIEF.md
# USB Device Status Registers with Setup Write Lockout

This block is the small register set that a USB device controller's serial interface engine shares with the microcontroller firmware. It holds the device address and its enable bit, a sticky flag that records any bus activity, and two endpoint-0 status flags. One flag records that a setup transaction has begun. The other records a transaction that ended with an ACK handshake. The engine reports events to the block as single-cycle strobes. The firmware reads and clears the flags through a small register port.

The block also guards the endpoint buffer RAM. While the setup flag is set, a CPU write to either of two protected buffer windows is refused. This keeps a setup packet that is arriving from being overwritten by firmware that is still filling an earlier IN buffer. Writes outside the windows always go through. A USB bus reset returns the address and the endpoint status to the power-up state. Register writes and hardware events take effect at the next clock edge. Read data is combinational.

Top module: `usb_devstat_regs`

## Requirements
- R1: After reset, all three registers read 0x00, `addr_en` is 0 and `dev_addr` is 0.
- R2: A write to register offset 0 stores the byte. Bit 7 drives `addr_en` and bits 6:0 drive `dev_addr`. Both outputs and the readback change at the next edge. Offset 3 always reads 0x00.
- R3: The activity flag (offset 2, bit 0) is set by `bus_active_evt` and stays set. Only a write of 0 to that bit clears it. Writing 1 has no effect.
- R4: `setup_start_evt` sets the setup flag (offset 1, bit 7) at the next edge.
- R5: `ack_evt` sets the acknowledge flag (offset 1, bit 6) at the next edge.
- R6: A write to offset 1 clears each flag whose bit is written 0 and leaves each flag whose bit is written 1 unchanged. If a hardware set and a clear of the same flag arrive in the same cycle, the set wins.
- R7: While the setup flag is set, `buf_wr_allow` is 0 for a buffer write whose address is in 0xE0–0xE7 or 0xF8–0xFF.
- R8: For a buffer write outside those windows, or while the setup flag is clear, `buf_wr_allow` equals `buf_we`. `buf_wr_allow` is never 1 without `buf_we`.
- R9: `bus_reset_evt` clears the address register and both endpoint flags at the next edge. It wins over same-cycle setup and ack events and over CPU writes. The activity flag is not changed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_active_evt | input | 1 | Strobe: non-idle bus event seen |
| setup_start_evt | input | 1 | Strobe: data phase of a setup transaction started |
| ack_evt | input | 1 | Strobe: transaction completed with ACK |
| bus_reset_evt | input | 1 | Strobe: USB bus reset detected |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| buf_we | input | 1 | CPU write request to buffer RAM |
| buf_addr | input | 8 | CPU buffer write address |
| buf_wr_allow | output | 1 | Gated buffer RAM write enable |
| dev_addr | output | 7 | Current device address |
| addr_en | output | 1 | Device address enable |

## Verification
The checker assumes that each event strobe describes a single clock cycle. It also assumes that its fixed window patterns match the default window parameters. Its flag-hold property treats a register write to offset 1 with the relevant bit 0 as the only clearing path apart from bus reset. The stimulus drives every strobe for exactly one cycle, changing it only at the falling edge. It changes the register and buffer buses only between rising edges. The bench keeps the windows at their default values.

// File: rtl/usb_devstat_regs.sv
module usb_devstat_regs #(
  parameter int AW = 2,
  parameter int BUF_AW = 8,
  parameter logic [BUF_AW-1:0] WIN_A_LO = 'hE0,
  parameter logic [BUF_AW-1:0] WIN_A_HI = 'hE7,
  parameter logic [BUF_AW-1:0] WIN_B_LO = 'hF8,
  parameter logic [BUF_AW-1:0] WIN_B_HI = 'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_active_evt,
  input  logic              setup_start_evt,
  input  logic              ack_evt,
  input  logic              bus_reset_evt,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              buf_we,
  input  logic [BUF_AW-1:0] buf_addr,
  output logic              buf_wr_allow,
  output logic [6:0]        dev_addr,
  output logic              addr_en
);
  localparam logic [AW-1:0] OFS_ADDR = AW'(0);
  localparam logic [AW-1:0] OFS_EP   = AW'(1);
  localparam logic [AW-1:0] OFS_BUS  = AW'(2);

  logic [7:0] addr_q;
  logic       setup_q, ack_q, act_q;

  wire wr_addr = reg_we && reg_addr == OFS_ADDR;
  wire wr_ep   = reg_we && reg_addr == OFS_EP;
  wire wr_bus  = reg_we && reg_addr == OFS_BUS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      setup_q <= 1'b0;
      ack_q   <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      if (bus_reset_evt) begin
        addr_q  <= '0;
        setup_q <= 1'b0;
        ack_q   <= 1'b0;
      end else begin
        if (wr_addr) addr_q <= reg_wdata;
        if (setup_start_evt) setup_q <= 1'b1;
        else if (wr_ep && !reg_wdata[7]) setup_q <= 1'b0;
        if (ack_evt) ack_q <= 1'b1;
        else if (wr_ep && !reg_wdata[6]) ack_q <= 1'b0;
      end
      if (bus_active_evt) act_q <= 1'b1;
      else if (wr_bus && !reg_wdata[0]) act_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_ADDR: reg_rdata = addr_q;
      OFS_EP:   reg_rdata = {setup_q, ack_q, 6'b0};
      OFS_BUS:  reg_rdata = {7'b0, act_q};
      default:  reg_rdata = 8'h00;
    endcase
  end

  wire in_win_a = buf_addr >= WIN_A_LO && buf_addr <= WIN_A_HI;
  wire in_win_b = buf_addr >= WIN_B_LO && buf_addr <= WIN_B_HI;

  assign buf_wr_allow = buf_we && !(setup_q && (in_win_a || in_win_b));
  assign dev_addr     = addr_q[6:0];
  assign addr_en      = addr_q[7];
endmodule

// File: rtl/usb_devstat_regs_chk.sv
module usb_devstat_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_active_evt,
  input logic       setup_start_evt,
  input logic       ack_evt,
  input logic       bus_reset_evt,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       buf_we,
  input logic [7:0] buf_addr,
  input logic       buf_wr_allow,
  input logic [6:0] dev_addr,
  input logic       addr_en,
  input logic       setup_q,
  input logic       ack_q,
  input logic       act_q
);
  wire guarded = buf_addr[7:3] == 5'b11100 || buf_addr[7:3] == 5'b11111;

  // R3
  act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_active_evt |=> act_q);
  // R3
  act_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> $past(reg_we && reg_addr == 2'd2 && !reg_wdata[0]));
  // R4
  setup_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_start_evt && !bus_reset_evt |=> setup_q);
  // R5
  ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt && !bus_reset_evt |=> ack_q);
  // R6
  setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_q && !bus_reset_evt && !(reg_we && reg_addr == 2'd1 && !reg_wdata[7]) |=> setup_q);
  // R7
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_q && buf_we && guarded |-> !buf_wr_allow);
  // R8
  open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we && !guarded |-> buf_wr_allow);
  // R8
  allow_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_allow |-> buf_we);
  // R9
  busrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_evt |=> !addr_en && dev_addr == 7'd0 && !setup_q && !ack_q);
endmodule

bind usb_devstat_regs usb_devstat_regs_chk u_chk (.*);

// File: tb/usb_devstat_regs_bench.sv
module usb_devstat_regs_bench;
  logic clk = 0, rst_n = 0;
  logic bus_active_evt = 0, setup_start_evt = 0, ack_evt = 0, bus_reset_evt = 0;
  logic reg_we = 0, buf_we = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, buf_addr = 0, reg_rdata;
  logic buf_wr_allow, addr_en;
  logic [6:0] dev_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usb_devstat_regs u_usb_devstat_regs (.*);

  // {address, allow expected while setup flag set}
  localparam logic [8:0] VEC [8] = '{
    {8'hE0, 1'b0}, {8'hE7, 1'b0}, {8'hE8, 1'b1}, {8'hDF, 1'b1},
    {8'hF7, 1'b1}, {8'hF8, 1'b0}, {8'hFF, 1'b0}, {8'h00, 1'b1}};

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(string req, logic [1:0] a, logic [7:0] exp);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd("R1", 2'd0, 8'h00); rd("R1", 2'd1, 8'h00); rd("R1", 2'd2, 8'h00);
    check("R1", {addr_en, dev_addr}, 8'h00);

    wr(2'd0, 8'h85);
    rd("R2", 2'd0, 8'h85);
    check("R2", {addr_en, dev_addr}, 8'h85);
    wr(2'd0, 8'h7F);
    check("R2", {addr_en, dev_addr}, 8'h7F);
    rd("R2", 2'd3, 8'h00);

    @(negedge clk) bus_active_evt = 1;
    @(negedge clk) bus_active_evt = 0;
    rd("R3", 2'd2, 8'h01);
    repeat (3) @(negedge clk);
    rd("R3", 2'd2, 8'h01);
    wr(2'd2, 8'h01); rd("R3", 2'd2, 8'h01);
    wr(2'd2, 8'h00); rd("R3", 2'd2, 8'h00);

    @(negedge clk) setup_start_evt = 1;
    @(negedge clk) setup_start_evt = 0;
    rd("R4", 2'd1, 8'h80);
    @(negedge clk) ack_evt = 1;
    @(negedge clk) ack_evt = 0;
    rd("R5", 2'd1, 8'hC0);
    wr(2'd1, 8'hFF); rd("R6", 2'd1, 8'hC0);
    wr(2'd1, 8'h40); rd("R6", 2'd1, 8'h40);
    wr(2'd1, 8'h00); rd("R6", 2'd1, 8'h00);
    @(negedge clk);
    setup_start_evt = 1; reg_we = 1; reg_addr = 2'd1; reg_wdata = 8'h00;
    @(negedge clk);
    setup_start_evt = 0; reg_we = 0;
    rd("R6 set beats clear", 2'd1, 8'h80);

    for (int i = 0; i < 8; i++) begin
      buf_we = 1; buf_addr = VEC[i][8:1];
      #1 check("R7", {7'b0, buf_wr_allow}, {7'b0, VEC[i][0]});
    end
    buf_we = 0; buf_addr = 8'hE0;
    #1 check("R8", {7'b0, buf_wr_allow}, 8'h00);
    wr(2'd1, 8'h00);
    for (int i = 0; i < 8; i++) begin
      buf_we = 1; buf_addr = VEC[i][8:1];
      #1 check("R8", {7'b0, buf_wr_allow}, 8'h01);
    end
    buf_we = 0;

    wr(2'd0, 8'h9A);
    @(negedge clk) begin setup_start_evt = 1; ack_evt = 1; bus_active_evt = 1; end
    @(negedge clk) begin setup_start_evt = 0; ack_evt = 0; bus_active_evt = 0; end
    rd("R9 pre", 2'd1, 8'hC0);
    @(negedge clk);
    bus_reset_evt = 1; setup_start_evt = 1; ack_evt = 1;
    reg_we = 1; reg_addr = 2'd0; reg_wdata = 8'hFF;
    @(negedge clk);
    bus_reset_evt = 0; setup_start_evt = 0; ack_evt = 0; reg_we = 0;
    rd("R9", 2'd0, 8'h00);
    check("R9", {addr_en, dev_addr}, 8'h00);
    rd("R9", 2'd1, 8'h00);
    rd("R9", 2'd2, 8'h01);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); end
    join_any
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule